// File: doc/BRIEF.md
# Serial EEPROM Image Loader with Additive Checksum

This block runs once after reset. Through a serial EEPROM master it first works out how many address bits the attached EEPROM really has, then reads every word of the EEPROM into a local word cache, and finally checks the image against a fixed 16-bit additive checksum. The rest of the chip reads the cached words through a combinational read port. It learns the outcome from a word count, a one-cycle completion pulse, a held checksum flag and a held pass flag. A policy input lets a corrupt image still count as a passing load.

The serial bit protocol belongs to the master. The loader raises `sm_req` with an address and the address width to use for that command. It holds them until the master returns `sm_ack` for one cycle with the read word and, on every response, the address width the master detected. The loader runs as four states. `ST_PROBE` issues the width-discovery read of address 0 with an 8-bit address. On the acknowledge it moves to `ST_FETCH`, which reads words 0 up to the last word in ascending order. The acknowledge of the last word moves it to `ST_JUDGE`, which lasts one cycle, compares the running sum and pulses `load_done`. `ST_JUDGE` always moves to `ST_HALT`, which stays idle until the next reset.

Top module: `ee_image_loader`

## Requirements
- R1: After reset the first request is a read of address 0 issued with an address width of PROBE_AW (8). While reset is active and right after it, `sm_req` is 1, `sm_addr` is 0 and `sm_aw` is 8.
- R2: The effective width is the width reported on the probe response. A report of 0 becomes 1, and a report above AW_MAX becomes AW_MAX. `word_count` reads 0 until the probe response arrives and then equals 2 raised to the effective width.
- R3: After the probe, each address from 0 to `word_count`-1 is requested exactly once, in ascending order, with `sm_aw` equal to the effective width. A request's address and width stay stable until its acknowledge.
- R4: Each acknowledged word is stored in the cache. `rd_data` returns the stored word for `rd_addr` below the number of words loaded so far.
- R5: `rd_data` is 0 for any `rd_addr` not yet loaded, which includes every address at or above `word_count`.
- R6: `csum_ok` is 1 when the modulo-2^16 sum of all loaded words, checksum word included, equals 16'hBABA, and 0 otherwise. It is set in the cycle after `load_done` and held until reset.
- R7: `load_pass` equals `csum_ok` OR `allow_bad_csum`, with the policy input sampled in the `load_done` cycle. It is held until reset.
- R8: `load_done` is high for exactly one cycle per reset, in the cycle after the acknowledge of the last word. No request is raised after it.
- R9: Reset clears `load_done`, `csum_ok`, `load_pass` and `word_count`, and empties the cache view (all reads return 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts a new load |
| allow_bad_csum | input | 1 | Policy: a checksum mismatch still gives a passing load |
| sm_req | output | 1 | Read request to the serial master, held until acknowledged |
| sm_addr | output | AW_MAX | Word address of the request |
| sm_aw | output | $clog2(AW_MAX+1) | Address width the master uses for this command |
| sm_ack | input | 1 | One-cycle read completion from the master |
| sm_rdata | input | DW | Word returned with `sm_ack` |
| sm_found_aw | input | $clog2(AW_MAX+1) | Address width detected by the master, valid with `sm_ack` |
| word_count | output | AW_MAX+1 | Number of words in the image, 2^width |
| load_done | output | 1 | One-cycle pulse when the load and the comparison are complete |
| csum_ok | output | 1 | Image sum matched 16'hBABA |
| load_pass | output | 1 | Load accepted: good checksum or policy allows a bad one |
| rd_addr | input | AW_MAX | Cache read address |
| rd_data | output | DW | Cached word, or 0 when not loaded |

## Verification
The bench builds the loader with its defaults: AW_MAX of 8, 16-bit words and a probe width of 8. The full 256-word cache, the last-word index at 255 and the 9-bit count of 256 are therefore all reached. The 4-bit width report lets the bench send 0 and values above 8, so both clamp directions are exercised next to the ordinary widths 1, 4 and 6. Images with a correct and a deliberately broken checksum word are each combined with both settings of the policy input.

// File: rtl/ee_load_pkg.sv
package ee_load_pkg;

    typedef enum logic [1:0] {
        ST_PROBE,
        ST_FETCH,
        ST_JUDGE,
        ST_HALT
    } ld_state_e;

endpackage

// File: rtl/ee_sum_acc.sv
module ee_sum_acc #(
    parameter int          DW     = 16,
    parameter logic [15:0] TARGET = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic [DW-1:0] add_word,
    output logic          match
);
    logic [DW-1:0] sum_q;

    // running modulo-2^DW sum, one word per acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_q + add_word;
        end
    end

    assign match = (sum_q == DW'(TARGET));

endmodule

// File: rtl/ee_word_cache.sv
module ee_word_cache #(
    parameter int AW_MAX = 8,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW_MAX-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW_MAX-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    localparam int DEPTH = 1 << AW_MAX;
    localparam int CW    = AW_MAX + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // words arrive in ascending order, so a fill level marks the loaded range
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (wr_en) begin
            fill_q <= fill_q + CW'(1);
        end
    end

    always_comb begin
        if ({1'b0, rd_addr} < fill_q) begin
            rd_data = mem[rd_addr];
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/ee_load_ctrl.sv
module ee_load_ctrl
    import ee_load_pkg::*;
#(
    parameter int AW_MAX   = 8,
    parameter int PROBE_AW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         allow_bad,
    input  logic                         sum_match,
    input  logic                         sm_ack,
    input  logic [$clog2(AW_MAX+1)-1:0]  sm_found_aw,
    output logic                         sm_req,
    output logic [AW_MAX-1:0]            sm_addr,
    output logic [$clog2(AW_MAX+1)-1:0]  sm_aw,
    output logic [AW_MAX:0]              word_count,
    output logic                         wr_en,
    output logic [AW_MAX-1:0]            wr_addr,
    output logic                         done,
    output logic                         csum_ok,
    output logic                         load_pass
);
    localparam int AWW = $clog2(AW_MAX + 1);
    localparam int CW  = AW_MAX + 1;

    ld_state_e         state_q, state_d;
    logic [AW_MAX-1:0] idx_q;
    logic [AWW-1:0]    aw_q;
    logic [CW-1:0]     count_q;
    logic [AWW-1:0]    eff_aw;
    logic              last_word;
    logic              ok_q, pass_q;

    // clamp the discovered width into 1..AW_MAX
    always_comb begin
        if (sm_found_aw == '0) begin
            eff_aw = AWW'(1);
        end else if (sm_found_aw > AWW'(AW_MAX)) begin
            eff_aw = AWW'(AW_MAX);
        end else begin
            eff_aw = sm_found_aw;
        end
    end

    assign last_word = ({1'b0, idx_q} == (count_q - CW'(1)));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PROBE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PROBE: if (sm_ack) state_d = ST_FETCH;
            ST_FETCH: if (sm_ack && last_word) state_d = ST_JUDGE;
            ST_JUDGE: state_d = ST_HALT;
            ST_HALT:  state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        sm_req  = 1'b0;
        sm_addr = '0;
        sm_aw   = aw_q;
        wr_en   = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_PROBE: begin
                sm_req  = 1'b1;
                sm_addr = '0;
                sm_aw   = AWW'(PROBE_AW);
            end
            ST_FETCH: begin
                sm_req  = 1'b1;
                sm_addr = idx_q;
                wr_en   = sm_ack;
            end
            ST_JUDGE: done = 1'b1;
            ST_HALT:  ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            aw_q    <= '0;
            count_q <= '0;
            ok_q    <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            if (state_q == ST_PROBE && sm_ack) begin
                aw_q    <= eff_aw;
                count_q <= CW'(1) << eff_aw;
            end
            if (state_q == ST_FETCH && sm_ack && !last_word) begin
                idx_q <= idx_q + AW_MAX'(1);
            end
            if (state_q == ST_JUDGE) begin
                ok_q   <= sum_match;
                pass_q <= sum_match | allow_bad;
            end
        end
    end

    assign wr_addr    = idx_q;
    assign word_count = count_q;
    assign csum_ok    = ok_q;
    assign load_pass  = pass_q;

endmodule

// File: rtl/ee_image_loader.sv
module ee_image_loader #(
    parameter int          AW_MAX      = 8,
    parameter int          DW          = 16,
    parameter int          PROBE_AW    = 8,
    parameter logic [15:0] CSUM_TARGET = 16'hBABA
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         allow_bad_csum,
    output logic                         sm_req,
    output logic [AW_MAX-1:0]            sm_addr,
    output logic [$clog2(AW_MAX+1)-1:0]  sm_aw,
    input  logic                         sm_ack,
    input  logic [DW-1:0]                sm_rdata,
    input  logic [$clog2(AW_MAX+1)-1:0]  sm_found_aw,
    output logic [AW_MAX:0]              word_count,
    output logic                         load_done,
    output logic                         csum_ok,
    output logic                         load_pass,
    input  logic [AW_MAX-1:0]            rd_addr,
    output logic [DW-1:0]                rd_data
);
    logic              wr_en;
    logic [AW_MAX-1:0] wr_addr;
    logic              sum_match;

    ee_load_ctrl #(
        .AW_MAX   (AW_MAX),
        .PROBE_AW (PROBE_AW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .allow_bad   (allow_bad_csum),
        .sum_match   (sum_match),
        .sm_ack      (sm_ack),
        .sm_found_aw (sm_found_aw),
        .sm_req      (sm_req),
        .sm_addr     (sm_addr),
        .sm_aw       (sm_aw),
        .word_count  (word_count),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .done        (load_done),
        .csum_ok     (csum_ok),
        .load_pass   (load_pass)
    );

    ee_sum_acc #(
        .DW     (DW),
        .TARGET (CSUM_TARGET)
    ) u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en   (wr_en),
        .add_word (sm_rdata),
        .match    (sum_match)
    );

    ee_word_cache #(
        .AW_MAX (AW_MAX),
        .DW     (DW)
    ) u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (sm_rdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/ee_image_loader_chk.sv
module ee_image_loader_chk #(
    parameter int AW_MAX = 8,
    parameter int DW     = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sm_req,
    input logic                         sm_ack,
    input logic [AW_MAX-1:0]            sm_addr,
    input logic [$clog2(AW_MAX+1)-1:0]  sm_aw,
    input logic [AW_MAX:0]              word_count,
    input logic                         load_done,
    input logic                         csum_ok,
    input logic                         load_pass,
    input logic [AW_MAX-1:0]            rd_addr,
    input logic [DW-1:0]                rd_data
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_req && !sm_ack) |=> (sm_req && $stable(sm_addr) && $stable(sm_aw)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    // R8
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !sm_req);

    // R6
    csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csum_ok |=> csum_ok);

    // R6
    csum_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csum_ok) |-> $past(load_done));

    // R7
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_pass |=> load_pass);

    // R5
    beyond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, rd_addr} >= word_count) |-> (rd_data == '0));

    // R2
    count_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_count));

endmodule

bind ee_image_loader ee_image_loader_chk #(
    .AW_MAX (AW_MAX),
    .DW     (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sm_req     (sm_req),
    .sm_ack     (sm_ack),
    .sm_addr    (sm_addr),
    .sm_aw      (sm_aw),
    .word_count (word_count),
    .load_done  (load_done),
    .csum_ok    (csum_ok),
    .load_pass  (load_pass),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
);

// File: tb/test_ee_image_loader.sv
module test_ee_image_loader;
    localparam int CLK_PERIOD = 10;
    localparam int AW_MAX     = 8;
    localparam int DW         = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              allow_bad_csum = 1'b0;
    logic              sm_req;
    logic [7:0]        sm_addr;
    logic [3:0]        sm_aw;
    logic              sm_ack = 1'b0;
    logic [15:0]       sm_rdata = '0;
    logic [3:0]        sm_found_aw = '0;
    logic [8:0]        word_count;
    logic              load_done;
    logic              csum_ok;
    logic              load_pass;
    logic [7:0]        rd_addr = '0;
    logic [15:0]       rd_data;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    logic [15:0] img [256];
    int  model_w   = 8;
    int  exp_next  = 0;
    bit  probe_pending = 1;
    int  lat       = 0;
    int  cyc       = 0;
    int  done_cnt  = 0;
    int  done_cyc  = 0;
    int  last_ack_cyc = 0;

    ee_image_loader i_ee_image_loader (
        .clk            (clk),
        .rst_n          (rst_n),
        .allow_bad_csum (allow_bad_csum),
        .sm_req         (sm_req),
        .sm_addr        (sm_addr),
        .sm_aw          (sm_aw),
        .sm_ack         (sm_ack),
        .sm_rdata       (sm_rdata),
        .sm_found_aw    (sm_found_aw),
        .word_count     (word_count),
        .load_done      (load_done),
        .csum_ok        (csum_ok),
        .load_pass      (load_pass),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_w(int r);
        if (r == 0) return 1;
        if (r > AW_MAX) return AW_MAX;
        return r;
    endfunction

    function automatic logic [15:0] sum16(int n);
        logic [15:0] s = '0;
        for (int i = 0; i < n; i++) s = s + img[i];
        return s;
    endfunction

    task automatic check(bit cond, string req, int act, int exp);
        vectors++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build_image(int n, bit good);
        logic [15:0] s = '0;
        for (int i = 0; i < 256; i++) img[i] = 16'($urandom);
        for (int i = 0; i < n - 1; i++) s = s + img[i];
        img[n-1] = 16'hBABA - s;
        if (!good) img[n-1] = img[n-1] + 16'h0001;
    endtask

    // serial master model: answers requests after 0..2 extra cycles
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            sm_ack = 1'b0;
            if (!rst_n) begin
                probe_pending = 1;
                exp_next = 0;
                done_cnt = 0;
                lat = int'($urandom % 3);
            end else begin
                if (load_done) begin
                    done_cnt++;
                    done_cyc = cyc;
                end
                if (sm_req) begin
                    if (lat != 0) begin
                        lat--;
                    end else begin
                        if (probe_pending) begin
                            // R1 probe read of address 0 at width 8
                            check(sm_addr == 8'd0, "R1 probe addr", int'(sm_addr), 0);
                            check(sm_aw == 4'd8, "R1 probe width", int'(sm_aw), 8);
                            probe_pending = 0;
                            sm_rdata = img[0];
                        end else begin
                            // R3 ascending addresses at the effective width
                            check(int'(sm_addr) == exp_next, "R3 fetch addr", int'(sm_addr), exp_next);
                            check(int'(sm_aw) == eff_w(model_w), "R3 fetch width", int'(sm_aw), eff_w(model_w));
                            exp_next++;
                            sm_rdata = img[sm_addr];
                        end
                        sm_found_aw = 4'(model_w);
                        sm_ack = 1'b1;
                        last_ack_cyc = cyc;
                        lat = int'($urandom % 3);
                    end
                end
            end
        end
    end

    task automatic run_load(int rep_w, bit good, bit allow);
        int n = 1 << eff_w(rep_w);
        logic [15:0] exp_d;
        bit exp_ok;
        int waited = 0;
        model_w = rep_w;
        build_image(n, good);
        exp_ok = (sum16(n) == 16'hBABA);
        allow_bad_csum = allow;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state, R1 probe request visible in reset
        check(load_done == 1'b0, "R9 done in reset", int'(load_done), 0);
        check(csum_ok == 1'b0, "R9 csum_ok in reset", int'(csum_ok), 0);
        check(load_pass == 1'b0, "R9 pass in reset", int'(load_pass), 0);
        check(word_count == 9'd0, "R9 count in reset", int'(word_count), 0);
        check(sm_req == 1'b1 && sm_addr == 8'd0 && sm_aw == 4'd8, "R1 reset request",
              int'({sm_req, sm_addr, sm_aw}), int'({1'b1, 8'd0, 4'd8}));
        rd_addr = 8'd0;
        #1;
        check(rd_data == 16'd0, "R9 empty cache", int'(rd_data), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R5 last word not loaded yet
        rd_addr = 8'(n - 1);
        #1;
        check(rd_data == 16'd0, "R5 unloaded read", int'(rd_data), 0);
        while (done_cnt == 0 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(done_cnt == 1, "R8 done seen", done_cnt, 1);
        check(done_cyc == last_ack_cyc + 1, "R8 done timing", done_cyc - last_ack_cyc, 1);
        check(exp_next == n, "R3 words requested", exp_next, n);
        check(int'(word_count) == n, "R2 word count", int'(word_count), n);
        @(negedge clk);
        check(csum_ok == exp_ok, "R6 checksum flag", int'(csum_ok), int'(exp_ok));
        check(load_pass == (exp_ok | allow), "R7 pass flag", int'(load_pass), int'(exp_ok | allow));
        allow_bad_csum = ~allow;
        repeat (5) @(negedge clk);
        check(done_cnt == 1, "R8 single pulse", done_cnt, 1);
        check(sm_req == 1'b0, "R8 no request after done", int'(sm_req), 0);
        check(csum_ok == exp_ok, "R6 checksum held", int'(csum_ok), int'(exp_ok));
        check(load_pass == (exp_ok | allow), "R7 pass held", int'(load_pass), int'(exp_ok | allow));
        for (int a = 0; a < 256; a++) begin
            rd_addr = 8'(a);
            #1;
            exp_d = (a < n) ? img[a] : 16'd0;
            if (a < n) check(rd_data == exp_d, "R4 cached word", int'(rd_data), int'(exp_d));
            else       check(rd_data == exp_d, "R5 beyond count", int'(rd_data), int'(exp_d));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed corners
        run_load(6,  1'b1, 1'b0);
        run_load(8,  1'b0, 1'b0);
        run_load(4,  1'b0, 1'b1);
        run_load(1,  1'b1, 1'b0);
        run_load(0,  1'b1, 1'b0);   // R2 clamp up to 1
        run_load(12, 1'b1, 1'b1);   // R2 clamp down to 8
        run_load(8,  1'b1, 1'b0);
        // random mix
        for (int k = 0; k < 6; k++) begin
            run_load(int'($urandom % 10), 1'($urandom), 1'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule